// File: doc/BRIEF.md
# Display Power-On Reset Sequencer

This block brings a small serial LCD controller out of reset after power-up. A `start` pulse samples four configuration straps, switches the panel supply enable, and then either runs the full reset flow or skips it. The full flow pulses the active-low panel reset pin, waits for the controller to recover, issues a software-reset command and waits again before it signals completion. In conditional mode the block first reads the controller's power-mode status. If the panel reports that its display is already running, for example because an earlier boot stage left it on, the reset is skipped and the block reports "already on".

Commands leave the block on a simple request/acknowledge interface. The block holds an 8-bit opcode and a read flag until the transport acknowledges them, and the transport returns a success bit and one read byte with that acknowledge. A `stop` pulse shuts the panel down. It either pulses a backlight-off strobe or, when no backlight is fitted, requests a memory-write command that the transport fills with zero pixels. After that it drops the supply enable. Every delay is a nanosecond parameter that is turned into a clock-cycle count from the clock frequency parameter.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, panel_rst_n=1, reg_en=0, bl_off=0, cmd_req=0, done=0, already_on=0 and fail=0.
- R2: A start pulse accepted in idle clears already_on and fail, and loads reg_en with cfg_reg in the following cycle.
- R3: With cfg_cond=1 the first request is a read (cmd_rd=1) of opcode 0x0A. If it is acknowledged with cmd_ok=1 and the data with bits 0, 1 and 7 ignored equals 0x1C, done pulses together with already_on=1 and fail=0, and neither a pin pulse nor a software reset follows.
- R4: Any other read outcome runs the full flow. This covers the power-on default 0x08, any value with bit 5 or bit 6 set, and an acknowledge with cmd_ok=0.
- R5: With cfg_hwrst=1, panel_rst_n is low for exactly L = ceil(RST_LOW_NS·CLK_HZ/1e9) cycles (at least 1). After it is released, exactly R = ceil(RST_REC_NS·CLK_HZ/1e9) cycles pass before the software-reset request appears. With cfg_hwrst=0 the pin stays high.
- R6: The full flow always issues a write request (cmd_rd=0) with opcode 0x01. Without a reset pin and without conditional mode, that request is up in the cycle after start.
- R7: After a successful software-reset acknowledge, done rises exactly W cycles later, with fail=0 and already_on=0. W is ceil(SWR_HW_NS·CLK_HZ/1e9) when a reset pin was used and ceil(SWR_NOHW_NS·CLK_HZ/1e9) otherwise.
- R8: A software-reset acknowledge with cmd_ok=0 gives done in the next cycle with fail=1, and drops reg_en in that same cycle.
- R9: done is a single-cycle pulse. cmd_req and cmd_code stay unchanged until cmd_ack. After an acknowledge, the request either drops or moves to a different opcode.
- R10: A stop pulse with cfg_bl=1 gives a one-cycle bl_off pulse in the next cycle, then reg_en=0 and a done pulse one cycle after that. No command is issued.
- R11: A stop pulse with cfg_bl=0 issues a write request with opcode 0x2C. On its acknowledge, whether it succeeded or not, reg_en drops and done pulses.
- R12: start and stop pulses that arrive while a sequence is in progress have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Power-up request pulse |
| stop | input | 1 | Shutdown request pulse |
| cfg_cond | input | 1 | Conditional mode: read status before resetting |
| cfg_hwrst | input | 1 | A hardware reset pin is fitted |
| cfg_reg | input | 1 | A supply regulator is fitted |
| cfg_bl | input | 1 | A backlight is fitted |
| cmd_ack | input | 1 | Transport acknowledges the current request |
| cmd_ok | input | 1 | The acknowledged command succeeded |
| cmd_rdata | input | 8 | Read byte returned with the acknowledge |
| panel_rst_n | output | 1 | Active-low panel reset pin |
| reg_en | output | 1 | Panel supply enable |
| bl_off | output | 1 | Backlight-off strobe |
| cmd_req | output | 1 | Command request, held until acknowledged |
| cmd_code | output | 8 | Command opcode |
| cmd_rd | output | 1 | Request is a one-byte read |
| done | output | 1 | One-cycle completion pulse |
| already_on | output | 1 | Last power-up found the display running |
| fail | output | 1 | Last power-up failed at software reset |

## Verification
reg_en, a pin driven low and a request issued without a pin all follow one cycle after the start edge. A done pulse from a read or failed-reset acknowledge appears in the cycle after that acknowledge edge, and the normal done arrives exactly W cycles after the software-reset acknowledge. The bench keeps a free-running cycle count, samples it on falling edges, and compares differences against L, R and W, which it computes from microsecond figures. It does not predict absolute cycle numbers. Pulse widths are measured by counting the falling edges during which the pin stays low, and single-cycle outputs are checked again one falling edge later to confirm that they have dropped.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CMD,
    ST_HW_LOW,
    ST_HW_REC,
    ST_SWR_CMD,
    ST_SWR_WAIT,
    ST_BLANK_CMD,
    ST_BL_OFF
  } seq_state_e;

  localparam logic [7:0] OPC_SOFT_RESET = 8'h01;
  localparam logic [7:0] OPC_READ_PWR   = 8'h0A;
  localparam logic [7:0] OPC_MEM_WRITE  = 8'h2C;

  localparam logic [7:0] PWR_RSVD_MASK  = 8'h83;
  localparam logic [7:0] PWR_ON_PATTERN = 8'h1C;

  // Round a duration up to whole clock cycles, never below one cycle.
  function automatic longint unsigned ns_to_cycles(input longint unsigned ns,
                                                   input longint unsigned clk_hz);
    longint unsigned c;
    c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Display counts as running only for the exact masked pattern.
  function automatic logic power_reports_on(input logic [7:0] v);
    return (v & ~PWR_RSVD_MASK) == PWR_ON_PATTERN;
  endfunction

endpackage

// File: rtl/pps_wait_timer.sv
module pps_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired = (cnt_q == '0);

  // R7: once run out, the timer stays run out until reloaded
  p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/pps_status_check.sv
module pps_status_check (
  input  logic [7:0] pwr_val,
  input  logic       rd_ok,
  output logic       disp_on
);
  import pps_pkg::*;

  // A failed read never counts as display-on (R4).
  assign disp_on = rd_ok && power_reports_on(pwr_val);

endmodule

// File: rtl/pps_seq_fsm.sv
module pps_seq_fsm
  import pps_pkg::*;
#(
  parameter int unsigned      CNT_W  = 8,
  parameter logic [CNT_W-1:0] LOW_LD = '0,
  parameter logic [CNT_W-1:0] REC_LD = '0,
  parameter logic [CNT_W-1:0] WHW_LD = '0,
  parameter logic [CNT_W-1:0] WNO_LD = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cfg_cond,
  input  logic             cfg_hwrst,
  input  logic             cfg_reg,
  input  logic             cfg_bl,
  input  logic             cmd_ack,
  input  logic             cmd_ok,
  input  logic             disp_on,
  input  logic             tmr_expired,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             panel_rst_n,
  output logic             reg_en,
  output logic             bl_off,
  output logic             cmd_req,
  output logic [7:0]       cmd_code,
  output logic             cmd_rd,
  output logic             done,
  output logic             already_on,
  output logic             fail
);

  seq_state_e state_q, state_d;
  logic       hw_q, hw_d;

  // named internal events
  logic ev_start, ev_stop, ev_ack;
  logic reg_wr, reg_val, done_d, on_set, fail_set, bl_d, clr_status;

  assign ev_start = (state_q == ST_IDLE) && start;
  assign ev_stop  = (state_q == ST_IDLE) && !start && stop;
  assign ev_ack   = cmd_req && cmd_ack;

  always_comb begin
    state_d    = state_q;
    hw_d       = hw_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    reg_wr     = 1'b0;
    reg_val    = 1'b0;
    done_d     = 1'b0;
    on_set     = 1'b0;
    fail_set   = 1'b0;
    bl_d       = 1'b0;
    clr_status = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ev_start) begin
          clr_status = 1'b1;
          hw_d       = cfg_hwrst;
          reg_wr     = 1'b1;
          reg_val    = cfg_reg;
          if (cfg_cond) begin
            state_d = ST_RD_CMD;
          end else if (cfg_hwrst) begin
            state_d  = ST_HW_LOW;
            tmr_load = 1'b1;
            tmr_val  = LOW_LD;
          end else begin
            state_d = ST_SWR_CMD;
          end
        end else if (ev_stop) begin
          clr_status = 1'b1;
          if (cfg_bl) begin
            bl_d    = 1'b1;
            state_d = ST_BL_OFF;
          end else begin
            state_d = ST_BLANK_CMD;
          end
        end
      end
      ST_RD_CMD: begin
        if (cmd_ack) begin
          if (disp_on) begin
            done_d  = 1'b1;
            on_set  = 1'b1;
            state_d = ST_IDLE;
          end else if (hw_q) begin
            state_d  = ST_HW_LOW;
            tmr_load = 1'b1;
            tmr_val  = LOW_LD;
          end else begin
            state_d = ST_SWR_CMD;
          end
        end
      end
      ST_HW_LOW: begin
        if (tmr_expired) begin
          state_d  = ST_HW_REC;
          tmr_load = 1'b1;
          tmr_val  = REC_LD;
        end
      end
      ST_HW_REC: begin
        if (tmr_expired) state_d = ST_SWR_CMD;
      end
      ST_SWR_CMD: begin
        if (cmd_ack) begin
          if (cmd_ok) begin
            state_d  = ST_SWR_WAIT;
            tmr_load = 1'b1;
            tmr_val  = hw_q ? WHW_LD : WNO_LD;
          end else begin
            reg_wr   = 1'b1;
            reg_val  = 1'b0;
            fail_set = 1'b1;
            done_d   = 1'b1;
            state_d  = ST_IDLE;
          end
        end
      end
      ST_SWR_WAIT: begin
        if (tmr_expired) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_BLANK_CMD: begin
        if (cmd_ack) begin
          reg_wr  = 1'b1;
          reg_val = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_BL_OFF: begin
        reg_wr  = 1'b1;
        reg_val = 1'b0;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hw_q       <= 1'b0;
      reg_en     <= 1'b0;
      bl_off     <= 1'b0;
      done       <= 1'b0;
      already_on <= 1'b0;
      fail       <= 1'b0;
    end else begin
      state_q <= state_d;
      hw_q    <= hw_d;
      bl_off  <= bl_d;
      done    <= done_d;
      if (reg_wr) reg_en <= reg_val;
      if (clr_status) begin
        already_on <= 1'b0;
        fail       <= 1'b0;
      end else begin
        if (on_set)   already_on <= 1'b1;
        if (fail_set) fail       <= 1'b1;
      end
    end
  end

  always_comb begin
    panel_rst_n = (state_q != ST_HW_LOW);
    cmd_req     = 1'b0;
    cmd_rd      = 1'b0;
    cmd_code    = 8'h00;
    case (state_q)
      ST_RD_CMD:    begin cmd_req = 1'b1; cmd_rd = 1'b1; cmd_code = OPC_READ_PWR;   end
      ST_SWR_CMD:   begin cmd_req = 1'b1;                cmd_code = OPC_SOFT_RESET; end
      ST_BLANK_CMD: begin cmd_req = 1'b1;                cmd_code = OPC_MEM_WRITE;  end
      default: ;
    endcase
  end

  // R9: request and opcode hold until acknowledged
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_code)));

  // R9: after an acknowledge the request drops or moves on
  p_req_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> (!cmd_req || (cmd_code != $past(cmd_code))));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: backlight strobe lasts one cycle
  p_bl_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bl_off |=> !bl_off);

  // R5: releasing the pin is followed by recovery, not by an immediate command
  p_release_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(panel_rst_n) |-> !cmd_req);

  // R12: a stop seen while busy never strobes the backlight
  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && stop) |=> !bl_off);

endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned RST_LOW_NS  = 20_000,
  parameter int unsigned RST_REC_NS  = 120_000_000,
  parameter int unsigned SWR_HW_NS   = 5_000_000,
  parameter int unsigned SWR_NOHW_NS = 120_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop,
  input  logic       cfg_cond,
  input  logic       cfg_hwrst,
  input  logic       cfg_reg,
  input  logic       cfg_bl,
  input  logic       cmd_ack,
  input  logic       cmd_ok,
  input  logic [7:0] cmd_rdata,
  output logic       panel_rst_n,
  output logic       reg_en,
  output logic       bl_off,
  output logic       cmd_req,
  output logic [7:0] cmd_code,
  output logic       cmd_rd,
  output logic       done,
  output logic       already_on,
  output logic       fail
);
  import pps_pkg::*;

  localparam int unsigned LOW_CYC = 32'(ns_to_cycles(64'(RST_LOW_NS),  64'(CLK_HZ)));
  localparam int unsigned REC_CYC = 32'(ns_to_cycles(64'(RST_REC_NS),  64'(CLK_HZ)));
  localparam int unsigned WHW_CYC = 32'(ns_to_cycles(64'(SWR_HW_NS),   64'(CLK_HZ)));
  localparam int unsigned WNO_CYC = 32'(ns_to_cycles(64'(SWR_NOHW_NS), 64'(CLK_HZ)));
  localparam int unsigned MAX_CYC = max2(max2(LOW_CYC, REC_CYC), max2(WHW_CYC, WNO_CYC));
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             disp_on;

  pps_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  pps_status_check u_status (
    .pwr_val (cmd_rdata),
    .rd_ok   (cmd_ok),
    .disp_on (disp_on)
  );

  pps_seq_fsm #(
    .CNT_W  (CNT_W),
    .LOW_LD (CNT_W'(LOW_CYC - 1)),
    .REC_LD (CNT_W'(REC_CYC - 1)),
    .WHW_LD (CNT_W'(WHW_CYC - 1)),
    .WNO_LD (CNT_W'(WNO_CYC - 1))
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .stop        (stop),
    .cfg_cond    (cfg_cond),
    .cfg_hwrst   (cfg_hwrst),
    .cfg_reg     (cfg_reg),
    .cfg_bl      (cfg_bl),
    .cmd_ack     (cmd_ack),
    .cmd_ok      (cmd_ok),
    .disp_on     (disp_on),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .panel_rst_n (panel_rst_n),
    .reg_en      (reg_en),
    .bl_off      (bl_off),
    .cmd_req     (cmd_req),
    .cmd_code    (cmd_code),
    .cmd_rd      (cmd_rd),
    .done        (done),
    .already_on  (already_on),
    .fail        (fail)
  );

  // R8: a failed power-up never leaves the supply enabled
  p_fail_regoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> !reg_en);

  // R3: the two outcome flags never appear together with done
  p_status_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(already_on && fail));

endmodule

// File: tb/tb_panel_pwr_seq.sv
`timescale 1ns/1ps
module tb_panel_pwr_seq;

  localparam longint HZ = 60_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0;
  logic       cfg_cond = 1'b0, cfg_hwrst = 1'b0, cfg_reg = 1'b0, cfg_bl = 1'b0;
  logic       cmd_ack = 1'b0, cmd_ok = 1'b0;
  logic [7:0] cmd_rdata = 8'h00;
  logic       panel_rst_n, reg_en, bl_off, cmd_req, cmd_rd, done, already_on, fail;
  logic [7:0] cmd_code;

  int     n_checks = 0;
  int     n_fail   = 0;
  longint cyc      = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  panel_pwr_seq #(.CLK_HZ(HZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cfg_cond(cfg_cond), .cfg_hwrst(cfg_hwrst), .cfg_reg(cfg_reg), .cfg_bl(cfg_bl),
    .cmd_ack(cmd_ack), .cmd_ok(cmd_ok), .cmd_rdata(cmd_rdata),
    .panel_rst_n(panel_rst_n), .reg_en(reg_en), .bl_off(bl_off),
    .cmd_req(cmd_req), .cmd_code(cmd_code), .cmd_rd(cmd_rd),
    .done(done), .already_on(already_on), .fail(fail)
  );

  // Cycles for a duration in microseconds, rounded up, at least one.
  function automatic longint us_cycles(input longint us);
    longint c;
    c = (us * HZ + 999_999) / 1_000_000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam longint L_EXP   = us_cycles(20);
  localparam longint R_EXP   = us_cycles(120_000);
  localparam longint W_HW    = us_cycles(5_000);
  localparam longint W_NOHW  = us_cycles(120_000);

  // {cond, hwrst, reg, rd_ok, rdata[7:0], swr_ok}
  localparam int NV = 7;
  localparam logic [12:0] VECS [0:NV-1] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1},  // full flow with pin
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1},  // no pin, no regulator
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h9F, 1'b1},  // reserved bits set, display on
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h08, 1'b1},  // power-on default: not on
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h1C, 1'b1},  // read failed
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0},  // soft reset fails
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h3C, 1'b1}   // partial-mode bit: not on
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(input logic cond, input logic hw, input logic rg,
                      input logic bl, input logic is_stop);
    @(negedge clk);
    cfg_cond = cond; cfg_hwrst = hw; cfg_reg = rg; cfg_bl = bl;
    if (is_stop) stop = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  task automatic wait_req();
    while (!cmd_req) @(negedge clk);
  endtask

  // Called at a falling edge with the request up; returns at the falling edge
  // just after the acknowledge edge.
  task automatic serve(input logic [7:0] code, input logic rd, input logic ok,
                       input logic [7:0] data, input string req);
    check(req, cmd_code, code);
    check(req, cmd_rd, rd);
    @(negedge clk);
    check("R9 hold req", cmd_req, 1);
    check("R9 hold code", cmd_code, code);
    cmd_ack = 1'b1; cmd_ok = ok; cmd_rdata = data;
    @(negedge clk);
    cmd_ack = 1'b0; cmd_ok = 1'b0; cmd_rdata = 8'h00;
  endtask

  task automatic run_vec(input logic [12:0] v);
    logic       cond, hw, rg, rd_ok, swr_ok, on;
    logic [7:0] rdata;
    longint     n, t;
    {cond, hw, rg, rd_ok, rdata, swr_ok} = v;
    kick(cond, hw, rg, 1'b0, 1'b0);
    check("R2 reg_en", reg_en, rg);
    check("R2 fail cleared", fail, 0);
    check("R2 already_on cleared", already_on, 0);
    if (cond) begin
      wait_req();
      serve(8'h0A, 1'b1, rd_ok, rdata, "R3 read");
      on = rd_ok && (rdata[6:2] == 5'b00111);
      if (on) begin
        check("R3 done", done, 1);
        check("R3 already_on", already_on, 1);
        check("R3 fail", fail, 0);
        check("R3 pin", panel_rst_n, 1);
        repeat (3) begin
          @(negedge clk);
          check("R3 no command", cmd_req, 0);
          check("R3 no pin", panel_rst_n, 1);
        end
        return;
      end
    end else if (!hw) begin
      check("R6 immediate req", cmd_req, 1);
    end
    if (hw) begin
      check("R4/R5 pin low", panel_rst_n, 0);
      n = 0;
      while (!panel_rst_n) begin n++; @(negedge clk); end
      check("R5 low width", n, L_EXP);
      t = cyc;
      while (!cmd_req) @(negedge clk);
      check("R5 recovery", cyc - t, R_EXP);
    end else begin
      while (!cmd_req) begin
        check("R5 no pin", panel_rst_n, 1);
        @(negedge clk);
      end
    end
    wait_req();
    serve(8'h01, 1'b0, swr_ok, 8'h00, "R6 soft reset");
    t = cyc;
    if (!swr_ok) begin
      check("R8 done", done, 1);
      check("R8 fail", fail, 1);
      check("R8 reg_en", reg_en, 0);
      check("R8 already_on", already_on, 0);
      @(negedge clk);
      check("R9 done pulse", done, 0);
      return;
    end
    while (!done) @(negedge clk);
    check("R7 wait", cyc - t, hw ? W_HW : W_NOHW);
    check("R7 fail", fail, 0);
    check("R7 already_on", already_on, 0);
    check("R7 reg_en", reg_en, rg);
    @(negedge clk);
    check("R9 done pulse", done, 0);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    longint t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin", panel_rst_n, 1);
    check("R1 reg_en", reg_en, 0);
    check("R1 bl_off", bl_off, 0);
    check("R1 cmd_req", cmd_req, 0);
    check("R1 done", done, 0);
    check("R1 already_on", already_on, 0);
    check("R1 fail", fail, 0);

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i]);
      repeat (2) @(negedge clk);
    end

    // R10: shutdown with backlight
    kick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R10 bl_off", bl_off, 1);
    check("R10 reg_en held", reg_en, 1);
    check("R10 no cmd", cmd_req, 0);
    @(negedge clk);
    check("R10 bl_off pulse", bl_off, 0);
    check("R10 reg_en off", reg_en, 0);
    check("R10 done", done, 1);
    check("R10 no cmd", cmd_req, 0);
    @(negedge clk);
    check("R9 done pulse", done, 0);

    // power up again (display already on) to have the supply enabled
    run_vec(VECS[2]);
    check("R2 reg_en on", reg_en, 1);

    // R11: shutdown with blanking
    kick(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R11 bl_off", bl_off, 0);
    check("R11 req", cmd_req, 1);
    check("R11 reg held", reg_en, 1);
    serve(8'h2C, 1'b0, 1'b0, 8'h00, "R11 blank");
    check("R11 done", done, 1);
    check("R11 reg_en off", reg_en, 0);

    // R12: start and stop ignored while busy
    repeat (2) @(negedge clk);
    kick(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    start = 1'b1; stop = 1'b1; cfg_reg = 1'b0;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    check("R12 no bl_off", bl_off, 0);
    check("R12 reg_en kept", reg_en, 1);
    check("R12 pin still low", panel_rst_n, 0);
    wait_req();
    serve(8'h01, 1'b0, 1'b1, 8'h00, "R12 soft reset");
    t = cyc;
    while (!done) @(negedge clk);
    check("R12 wait unchanged", cyc - t, W_HW);
    check("R12 fail", fail, 0);
    check("R12 reg_en", reg_en, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule